// File: doc/BRIEF.md
# Ethernet PHY Discovery Scanner

This engine searches the station management bus for an attached Ethernet PHY. Each start command makes it walk the PHY addresses upward from 0. At each address it reads the first identifier register. If the value is all ones or all zeros, nothing answers there and the scan moves to the next address. If the value is valid, the engine reads the second identifier register at the same address. It then joins the two halves into a 32-bit identifier.

The identifier, with its low revision nibble removed, is looked up in a parameter table of known devices. The result is reported with a one-cycle done pulse, together with the address, the full identifier and either a table index or an unknown flag. If all 32 addresses come back empty, the engine reports not-found and sets its clock divider to zero, which parks the management clock low until the next start.

The management clock is made from the system clock. A divider value is derived from the system frequency, aiming at roughly 2.5 MHz. Read frames change the data line on the falling clock edge and sample returned data on the rising edge.

Top module: `mdio_phy_scan`

## Requirements
- R1: The divider value is ((((CLK_HZ/2 + 4999999) / 2500000) / 2) & 63) << 1. `mdc` stays high for that many system clocks and low for that many, so 12.5 MHz gives value 4 and an 8-clock period. A divider value of 0 holds `mdc` low.
- R2: Each read frame sends 64 clock slots in this order: 32 ones, start bits 0 then 1, read opcode 1 then 0, the 5-bit PHY address MSB first, then the 5-bit register number MSB first. `mdio_o` changes only at falling edges of `mdc`.
- R3: During the two turnaround slots and the 16 data slots, `mdio_oe` is 0. Data bits are taken MSB first from `mdio_i` at the rising `mdc` edges of the data slots.
- R4: After start, the scan begins at address 0 and reads register 2. A returned value of 0xFFFF or 0x0000 moves the scan to the next address.
- R5: A valid register-2 value becomes identifier bits 31:16. The next frame reads register 3 at the same address, and its value becomes bits 15:0.
- R6: `phy_id` shifted right by 4 is compared with each table entry (default entry 0 = 0x0022561, entry 1 = 0x20005C9). The lowest matching entry index appears on `match_idx` with `unknown`=0. If no entry matches, `unknown`=1 and `match_idx`=0.
- R7: When address 31 also answers with an invalid value, `done` pulses with `not_found`=1. `mdc` then stays low and `mdio_oe` stays 0 until the next start. A later start re-enables the clock and scans again from address 0.
- R8: `done` is high for exactly one cycle, and the result outputs are valid while it is high. `busy` is high from the cycle after start until done. A start while busy is ignored.
- R9: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `not_found` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| mdio_i | input | 1 | Management data line as seen by the block |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for `mdio_o`; 0 releases the line |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| not_found | output | 1 | No PHY answered at any address |
| phy_addr | output | 5 | Address where the PHY answered |
| phy_id | output | 32 | Full identifier, register 2 in the high half |
| match_idx | output | 1 | Index of the matching table entry |
| unknown | output | 1 | Identifier matched no table entry |

## Verification
The hardest case to reach is the exhausted scan. It takes 32 complete empty frames, and the last one ends while `mdc` is high, so the clock has to be forced low in the middle of a phase and then restarted cleanly by a later start. The bench drives this with a PHY model that leaves every address unanswered. It watches `mdc` for a quiet window, and then runs a scan with a device at address 2 to show the clock comes back. A mixed case puts 0x0000 at address 3 and the device at address 5, so both invalid codes are skipped before a match. In that case a second start pulse arrives mid-scan, and the frame queue confirms the scan did not restart.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;
  localparam int ID_W   = 2 * DATA_W;
  localparam int DIV_W  = 7;
  localparam int KEY_W  = 28;

  localparam logic [REG_W-1:0] REG_ID_HI = 5'd2;
  localparam logic [REG_W-1:0] REG_ID_LO = 5'd3;

  typedef enum logic [1:0] {SCAN_IDLE, SCAN_HI, SCAN_LO} scan_state_t;

  // Divider value aiming at about 2.5 MHz management clock.
  function automatic logic [DIV_W-1:0] mdc_div_field(input int clk_hz);
    int steps;
    steps = ((clk_hz / 2 + 4999999) / 2500000) / 2;
    return {steps[5:0], 1'b0};
  endfunction
endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (div_i != '0) && (cnt >= div_i - 1'b1);
  assign rise_o = at_end & ~mdc_o;
  assign fall_o = at_end & mdc_o;

  always_ff @(posedge clk) begin
    if (rst || div_i == '0) begin
      cnt   <= '0;
      mdc_o <= 1'b0;
    end else if (at_end) begin
      cnt   <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_mdc_off_R7: assert property (@(posedge clk) disable iff (rst)
    (div_i == '0) |=> !mdc_o) else $error("mdc not parked");

  assert_half_period_R1: assert property (@(posedge clk) disable iff (rst)
    ((div_i != '0) && ($past(div_i) != '0) && (mdc_o != $past(mdc_o)))
      |-> ($past(cnt) == $past(div_i) - 1'b1)) else $error("mdc toggled early");
endmodule

// File: rtl/mdio_read_frame.sv
module mdio_read_frame #(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [REG_W-1:0]  reg_addr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PRE_W  = 32;
  localparam int HDR_W  = PRE_W + 4 + ADDR_W + REG_W;
  localparam int SLOTS  = HDR_W + 2 + DATA_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] HDR_LAST = SLOT_W'(HDR_W - 1);
  localparam logic [SLOT_W-1:0] RX_FIRST = SLOT_W'(HDR_W + 2);
  localparam logic [SLOT_W-1:0] LAST     = SLOT_W'(SLOTS - 1);

  logic [HDR_W-1:0]  hdr_sh;
  logic [SLOT_W-1:0] slot;
  logic              pending, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_sh  <= '0;
      slot    <= '0;
      pending <= 1'b0;
      active  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !pending && !active) begin
        pending <= 1'b1;
        hdr_sh  <= {{PRE_W{1'b1}}, 4'b0110, phy_addr_i, reg_addr_i};
      end
      if (fall_i) begin
        if (pending) begin
          pending <= 1'b0;
          active  <= 1'b1;
          slot    <= '0;
          mdio_oe <= 1'b1;
          mdio_o  <= hdr_sh[HDR_W-1];
          hdr_sh  <= hdr_sh << 1;
        end else if (active) begin
          slot <= slot + 1'b1;
          if (slot < HDR_LAST) begin
            mdio_o <= hdr_sh[HDR_W-1];
            hdr_sh <= hdr_sh << 1;
          end else begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end
        end
      end
      if (rise_i && active) begin
        if (slot >= RX_FIRST) rdata_o <= {rdata_o[DATA_W-2:0], mdio_i};
        if (slot == LAST) begin
          active <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (active && slot > HDR_LAST) |-> !mdio_oe) else $error("line driven in read phase");

  assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(fall_i))
    else $error("mdio changed off falling edge");

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (!active && !pending)) else $error("frame started while busy");
endmodule

// File: rtl/mdio_phy_scan.sv
module mdio_phy_scan
  import mdio_scan_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int NUM_IDS = 2,
  parameter logic [NUM_IDS*KEY_W-1:0] KNOWN_IDS = {28'h20005C9, 28'h0022561},
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              not_found,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [ID_W-1:0]   phy_id,
  output logic [IDX_W-1:0]  match_idx,
  output logic              unknown
);
  localparam logic [DIV_W-1:0]  DIV_FIELD = mdc_div_field(CLK_HZ);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  scan_state_t       state;
  logic [DIV_W-1:0]  div_q;
  logic [ADDR_W-1:0] scan_addr;
  logic [REG_W-1:0]  rd_reg;
  logic              rd_start, fr_done, tick_rise, tick_fall;
  logic [DATA_W-1:0] fr_data, id_hi;
  logic [ID_W-1:0]   id_full, id_key;
  logic [NUM_IDS-1:0] hits;
  logic              hit_any, invalid;
  logic [IDX_W-1:0]  hit_idx;

  mdc_clock_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .div_i(div_q),
    .mdc_o(mdc), .rise_o(tick_rise), .fall_o(tick_fall)
  );

  mdio_read_frame #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .start_i(rd_start), .phy_addr_i(scan_addr),
    .reg_addr_i(rd_reg), .rise_i(tick_rise), .fall_i(tick_fall), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_o(fr_done), .rdata_o(fr_data)
  );

  assign invalid = (fr_data == '1) || (fr_data == '0);
  assign id_full = {id_hi, fr_data};
  assign id_key  = id_full >> 4;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_lookup
    assign hits[g] = (id_key == ID_W'(KNOWN_IDS[g*KEY_W +: KEY_W]));
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign busy = (state != SCAN_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SCAN_IDLE;
      div_q     <= DIV_FIELD;
      scan_addr <= '0;
      rd_reg    <= REG_ID_HI;
      rd_start  <= 1'b0;
      id_hi     <= '0;
      done      <= 1'b0;
      not_found <= 1'b0;
      phy_addr  <= '0;
      phy_id    <= '0;
      match_idx <= '0;
      unknown   <= 1'b0;
    end else begin
      rd_start <= 1'b0;
      done     <= 1'b0;
      case (state)
        SCAN_IDLE: if (start) begin
          div_q     <= DIV_FIELD;
          not_found <= 1'b0;
          scan_addr <= '0;
          rd_reg    <= REG_ID_HI;
          rd_start  <= 1'b1;
          state     <= SCAN_HI;
        end
        SCAN_HI: if (fr_done) begin
          if (!invalid) begin
            id_hi    <= fr_data;
            rd_reg   <= REG_ID_LO;
            rd_start <= 1'b1;
            state    <= SCAN_LO;
          end else if (scan_addr == ADDR_LAST) begin
            not_found <= 1'b1;
            done      <= 1'b1;
            div_q     <= '0;
            state     <= SCAN_IDLE;
          end else begin
            scan_addr <= scan_addr + 1'b1;
            rd_start  <= 1'b1;
          end
        end
        SCAN_LO: if (fr_done) begin
          phy_addr  <= scan_addr;
          phy_id    <= id_full;
          match_idx <= hit_idx;
          unknown   <= !hit_any;
          done      <= 1'b1;
          rd_reg    <= REG_ID_HI;
          state     <= SCAN_IDLE;
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle");

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SCAN_HI && fr_done && invalid && scan_addr != ADDR_LAST)
      |=> (scan_addr == $past(scan_addr) + 1'b1)) else $error("scan skipped an address");

  assert_park_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(not_found) |-> (div_q == '0 && !busy)) else $error("clock not parked");

  assert_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (state == SCAN_LO) |-> $stable(scan_addr)) else $error("address moved in second read");
endmodule

// File: tb/test_mdio_phy_scan.sv
module test_mdio_phy_scan;
  localparam int CLK_HZ = 12_500_000;   // divider value 4, mdc period 8 clocks

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, busy, done, not_found, unknown;
  logic [4:0]  phy_addr;
  logic [31:0] phy_id;
  logic [0:0]  match_idx;

  mdio_phy_scan #(.CLK_HZ(CLK_HZ)) i_mdio_phy_scan (
    .clk(clk), .rst(rst), .start(start), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .not_found(not_found), .phy_addr(phy_addr), .phy_id(phy_id),
    .match_idx(match_idx), .unknown(unknown)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY model
  logic        model_on [32];
  logic [31:0] model_id [32];
  int          zero_addr = -1;

  function automatic logic [15:0] model_resp(input logic [4:0] a, input logic [4:0] r);
    if (model_on[a]) return (r == 5'd2) ? model_id[a][31:16] : model_id[a][15:0];
    if (int'(a) == zero_addr) return 16'h0000;
    return 16'hFFFF;
  endfunction

  typedef struct packed {
    logic nf; logic [4:0] a; logic [31:0] id; logic [0:0] idx; logic unk;
  } res_t;
  logic [9:0] exp_frames[$];
  res_t       exp_res[$];

  // Frame monitor / responder
  initial begin
    forever begin
      logic [45:0] hdr;
      logic [15:0] resp;
      logic [9:0]  ef;
      bit          bad_oe;
      time         t0;
      bad_oe = 0;
      @(posedge mdio_oe);
      for (int k = 0; k < 46; k++) begin
        @(posedge mdc);
        if (k == 0) t0 = $time;
        if (k == 1) check($time - t0 == 64, "R1", "mdc period ns", $time - t0, 64);
        if (!mdio_oe) bad_oe = 1;
        hdr = {hdr[44:0], mdio_o};
      end
      check(hdr[45:10] == {32'hFFFFFFFF, 4'b0110}, "R2", "preamble/start/op",
            hdr[45:10], {32'hFFFFFFFF, 4'b0110});
      if (exp_frames.size() == 0) begin
        check(0, "R4", "unexpected frame addr/reg", hdr[9:0], 0);
        ef = hdr[9:0];
      end else begin
        ef = exp_frames.pop_front();
        check(hdr[9:0] == ef, "R4", "frame addr/reg", hdr[9:0], ef);
      end
      resp = model_resp(hdr[9:5], hdr[4:0]);
      for (int k = 46; k < 64; k++) begin
        @(negedge mdc);
        if (k >= 48) mdio_i = resp[63-k];
        @(posedge mdc);
        if (mdio_oe) bad_oe = 1;
      end
      #1 mdio_i = 1'b1;
      check(!bad_oe, "R3", "oe during header 1 / read phase 0", bad_oe, 0);
    end
  end

  // Result monitor (scoreboard)
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) check(!done, "R8", "done width", done, 0);
      if (done) begin
        if (exp_res.size() == 0) check(0, "R8", "unexpected done", 1, 0);
        else begin
          res_t e;
          e = exp_res.pop_front();
          check(not_found == e.nf, "R7", "not_found", not_found, e.nf);
          if (!e.nf) begin
            check(phy_addr == e.a, "R4", "phy_addr", phy_addr, e.a);
            check(phy_id == e.id, "R5", "phy_id", phy_id, e.id);
            check(match_idx == e.idx, "R6", "match_idx", match_idx, e.idx);
            check(unknown == e.unk, "R6", "unknown", unknown, e.unk);
          end
        end
      end
      prev_done <= done;
    end
  end

  // Driver
  task automatic run_scan(input int at, input logic [31:0] id, input int zaddr,
                          input logic idx, input logic unk, input bit restart_mid);
    res_t r;
    for (int a = 0; a < 32; a++) model_on[a] = 1'b0;
    zero_addr = zaddr;
    if (at >= 0) begin
      model_on[at] = 1'b1;
      model_id[at] = id;
    end
    for (int a = 0; a <= ((at >= 0) ? at : 31); a++) exp_frames.push_back({a[4:0], 5'd2});
    if (at >= 0) exp_frames.push_back({at[4:0], 5'd3});
    r.nf = (at < 0); r.a = at[4:0]; r.id = id; r.idx = idx; r.unk = unk;
    exp_res.push_back(r);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy, "R8", "busy after start", busy, 1);
    if (restart_mid) begin
      repeat (700) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) begin model_on[a] = 1'b0; model_id[a] = '0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!mdc, "R9", "mdc", mdc, 0);
    check(!mdio_oe, "R9", "mdio_oe", mdio_oe, 0);
    check(!busy, "R9", "busy", busy, 0);
    check(!done, "R9", "done", done, 0);
    check(!not_found, "R9", "not_found", not_found, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    run_scan(0, 32'h00225613, -1, 1'b0, 1'b0, 0);       // R5 R6 entry 0
    run_scan(5, 32'h20005C9A, 3, 1'b1, 1'b0, 1);        // R4 both invalid codes, R8 ignored start
    run_scan(31, 32'h12345678, -1, 1'b0, 1'b1, 0);      // R6 unknown at last address
    run_scan(-1, 32'h0, 7, 1'b0, 1'b0, 0);              // R7 nothing found
    begin
      bit moved;
      moved = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (mdc || mdio_oe) moved = 1;
      end
      check(!moved, "R7", "mdc/oe parked after not_found", moved, 0);
    end
    run_scan(2, 32'h0022561F, -1, 1'b0, 1'b0, 0);       // R7 recovery, R6 revision ignored
    repeat (50) @(negedge clk);
    check(exp_frames.size() == 0, "R4", "frames left", exp_frames.size(), 0);
    check(exp_res.size() == 0, "R8", "results left", exp_res.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule